// File: doc/BRIEF.md
# Serial-Bus Wiper Controller for a 256-Tap Potentiometer

This block is an I2C target that keeps the 8-bit wiper position of a 256-step resistive divider. It turns that position into a one-hot tap select and two shutdown controls: an open flag for the A terminal and a short flag from the wiper to the B terminal. The system clock samples the bus. SDA is open-drain, and the block only ever pulls it low through an output enable. One address bit comes from a strap pin, so two instances can share one bus.

A controller changes the setting with a three-byte write: target address, a command byte and a position byte. The command byte has two controls. One forces the position back to the middle of the range. The other parks the output at the B end. Parking keeps the stored position, and the controller can still update that position while the output is parked. A two-byte read returns the stored position.

A new setting takes effect only once the position byte has been acknowledged. A START or STOP that arrives earlier throws the whole write away.

Top module: `pot_wiper_ctrl`

## Requirements
- R1: After synchronous reset the stored position is 0x80. In that state `tap_sel` has only bit 128 set, both shutdown flags are low and `sda_oe` is low.
- R2: The block answers only to the 7-bit address {6'b010110, strap_a0}, sent MSB first, with the direction bit following as the 8th bit. A transaction to any other address gets no acknowledge and changes nothing.
- R3: A write has direction bit 0. The block pulls SDA low in the acknowledge slot of the address byte, the command byte and the position byte.
- R4: In the command byte, bit 6 requests midscale and bit 5 requests shutdown. Bits 7 and 4..0 have no effect.
- R5: A write with bit 6 set stores 0x80 and ignores the position byte.
- R6: When not shut down, `tap_sel` is one-hot at the index equal to the stored position.
- R7: A write with bit 5 set raises `term_a_open` and `wiper_to_b` and moves `tap_sel` to bit 0 only. The stored position is kept, and a read still returns it.
- R8: A position written while shut down is stored. A later write with bit 5 clear selects the tap from the value stored at that time.
- R9: A read has direction bit 1. After the address acknowledge, the block drives the stored position MSB first, one bit per SCL clock. It leaves SDA released in the controller's answer slot that follows.
- R10: A START or STOP before the position byte's acknowledge completes aborts the write. The stored position and shutdown state stay as they were.
- R11: A write commits only when SCL falls at the end of the position byte's acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| strap_a0 | input | 1 | Lowest target address bit |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired line) |
| sda_oe | output | 1 | 1 pulls SDA low |
| tap_sel | output | 256 | One-hot tap select |
| term_a_open | output | 1 | A terminal disconnected (shutdown) |
| wiper_to_b | output | 1 | Wiper tied to B terminal (shutdown) |

## Verification
The hardest case to reach is a write cut short inside the position byte. The stored position must survive it, and so must an earlier shutdown state. The stimulus reaches this by sending the address, the command and half the position bits, then raising a STOP or a new START while SCL is high. Shutdown writes, writes made while parked and midscale-with-data writes are mixed into the random sequence. Reads check the stored value directly, since the tap select hides it while the output is parked.

// File: rtl/pot_pkg.sv
package pot_pkg;
    localparam int BYTE_W = 8;
    localparam int TAPS = 1 << BYTE_W;
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [5:0] ADDR_PREFIX = 6'b010110;
    localparam logic [BYTE_W-1:0] MIDSCALE = BYTE_W'(1) << (BYTE_W - 1);
    localparam int RS_BIT = 6;
    localparam int SD_BIT = 5;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  rs;
        logic  sd;
        byte_t pos;
    } wr_cmd_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_INSTR, ST_IACK,
        ST_DATA, ST_DACK, ST_READ, ST_RACK
    } bus_state_e;

    function automatic logic addr_hit(byte_t rx, logic strap);
        return rx[BYTE_W-1:1] == {ADDR_PREFIX, strap};
    endfunction

    function automatic byte_t next_pos(wr_cmd_t c);
        return c.rs ? MIDSCALE : c.pos;
    endfunction
endpackage

// File: rtl/pot_bus_sync.sv
module pot_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_bit,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_sr;
    logic [STAGES:0] sda_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
        end else begin
            scl_sr <= {scl_sr[STAGES-1:0], scl_in};
            sda_sr <= {sda_sr[STAGES-1:0], sda_in};
        end
    end

    logic scl_s, scl_q, sda_s, sda_q;
    assign scl_s = scl_sr[STAGES-1];
    assign scl_q = scl_sr[STAGES];
    assign sda_s = sda_sr[STAGES-1];
    assign sda_q = sda_sr[STAGES];

    assign sda_bit   = sda_s;
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/pot_i2c_fsm.sv
module pot_i2c_fsm
    import pot_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    strap,
    input  logic    sda_bit,
    input  logic    scl_rise,
    input  logic    scl_fall,
    input  logic    start_det,
    input  logic    stop_det,
    input  byte_t   rd_value,
    output logic    sda_oe,
    output logic    cmd_valid,
    output wr_cmd_t cmd
);
    bus_state_e       state;
    logic [CNT_W-1:0] bit_cnt;
    byte_t            rx_sr;
    byte_t            tx_sr;
    logic             ins_rs, ins_sd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            ins_rs    <= 1'b0;
            ins_sd    <= 1'b0;
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
            end else if (stop_det) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_ADDR, ST_INSTR, ST_DATA: begin
                        if (scl_rise && bit_cnt != CNT_W'(BYTE_W)) begin
                            rx_sr   <= {rx_sr[BYTE_W-2:0], sda_bit};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR)
                                state <= addr_hit(rx_sr, strap) ? ST_AACK : ST_IDLE;
                            else if (state == ST_INSTR) begin
                                ins_rs <= rx_sr[RS_BIT];
                                ins_sd <= rx_sr[SD_BIT];
                                state  <= ST_IACK;
                            end else
                                state <= ST_DACK;
                        end
                    end
                    ST_AACK: if (scl_fall) begin
                        if (rx_sr[0]) begin
                            tx_sr <= rd_value;
                            state <= ST_READ;
                        end else begin
                            state <= ST_INSTR;
                        end
                    end
                    ST_IACK: if (scl_fall) state <= ST_DATA;
                    ST_DACK: if (scl_fall) begin
                        cmd_valid <= 1'b1;
                        cmd       <= '{rs: ins_rs, sd: ins_sd, pos: rx_sr};
                        state     <= ST_IDLE;
                    end
                    ST_READ: if (scl_fall) begin
                        tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                            bit_cnt <= '0;
                            state   <= ST_RACK;
                        end
                    end
                    ST_RACK: if (scl_fall) state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        sda_oe = 1'b0;
        if (state == ST_AACK || state == ST_IACK || state == ST_DACK)
            sda_oe = 1'b1;
        else if (state == ST_READ)
            sda_oe = ~tx_sr[BYTE_W-1];
    end

    // R10: a STOP always returns the engine to idle
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (rst)
        (stop_det && !start_det) |=> state == ST_IDLE);
    // R2: an idle engine never touches the bus
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE |-> !sda_oe);
    // R9: controller answer slot after read data is left free
    a_r9_rack_release: assert property (@(posedge clk) disable iff (rst)
        state == ST_RACK |-> !sda_oe);
    // R11: a commit only leaves the data acknowledge slot
    a_r11_commit_src: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_valid) |-> $past(state) == ST_DACK);
endmodule

// File: rtl/pot_wiper_regs.sv
module pot_wiper_regs
    import pot_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  wr_cmd_t         cmd,
    output byte_t           pos_q,
    output logic            sd_q,
    output logic [TAPS-1:0] tap_sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= MIDSCALE;
            sd_q  <= 1'b0;
        end else if (cmd_valid) begin
            pos_q <= next_pos(cmd);
            sd_q  <= cmd.sd;
        end
    end

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign tap_sel[i] = sd_q ? (i == 0) : (pos_q == BYTE_W'(i));
    end

    // R10/R11: position changes only on a commit
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(pos_q) && $stable(sd_q));
    // R5: midscale request wins over position byte
    a_r5_rs_mid: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.rs) |=> pos_q == MIDSCALE);
    // R6: exactly one tap selected
    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_sel) == 1);
    // R7: parked output sits on tap 0
    a_r7_park: assert property (@(posedge clk) disable iff (rst)
        sd_q |-> tap_sel[0]);
endmodule

// File: rtl/pot_wiper_ctrl.sv
module pot_wiper_ctrl
    import pot_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            strap_a0,
    input  logic            scl_in,
    input  logic            sda_in,
    output logic            sda_oe,
    output logic [TAPS-1:0] tap_sel,
    output logic            term_a_open,
    output logic            wiper_to_b
);
    logic    sda_bit, scl_rise, scl_fall, start_det, stop_det;
    logic    cmd_valid, sd_q;
    wr_cmd_t cmd;
    byte_t   pos_q;

    pot_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .sda_bit(sda_bit), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    pot_i2c_fsm u_fsm (
        .clk(clk), .rst(rst), .strap(strap_a0), .sda_bit(sda_bit),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_value(pos_q), .sda_oe(sda_oe),
        .cmd_valid(cmd_valid), .cmd(cmd)
    );

    pot_wiper_regs u_regs (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
        .pos_q(pos_q), .sd_q(sd_q), .tap_sel(tap_sel)
    );

    assign term_a_open = sd_q;
    assign wiper_to_b  = sd_q;
endmodule

// File: tb/pot_wiper_ctrl_test.sv
module pot_wiper_ctrl_test;
    localparam int Q = 8;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strap = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, term_a_open, wiper_to_b;
    logic [255:0] tap_sel;
    logic sda_line;
    int tests = 0;
    int fails = 0;
    logic [7:0] exp_pos = 8'h80;
    logic exp_sd = 1'b0;

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    pot_wiper_ctrl uut (
        .clk(clk), .rst(rst), .strap_a0(strap), .scl_in(scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .tap_sel(tap_sel), .term_a_open(term_a_open),
        .wiper_to_b(wiper_to_b)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] exp_taps(logic [7:0] p, logic sd);
        return sd ? 256'd1 : (256'd1 << p);
    endfunction

    task automatic chk_out(input string req);
        chk(req, tap_sel, exp_taps(exp_pos, exp_sd));
        chk(req, {254'd0, term_a_open, wiper_to_b}, {254'd0, exp_sd, exp_sd});
    endtask

    task automatic bus_start;
        sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q); scl = 1; tick(Q); scl = 0;
        end
        tick(1);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1; tick(Q); scl = 1; tick(Q / 2);
        ack = ~sda_line;
        tick(Q / 2); scl = 0; tick(Q);
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] ins, input logic [7:0] d,
                          output logic [2:0] acks);
        bus_start;
        send_byte({a, 1'b0}, acks[0]);
        send_byte(ins, acks[1]);
        send_byte(d, acks[2]);
        bus_stop;
        if (a == {6'b010110, strap}) begin
            exp_sd = ins[5];
            exp_pos = ins[6] ? 8'h80 : d;
        end
    endtask

    task automatic rd_txn(input logic [6:0] a, output logic ack, output logic [7:0] v,
                          output logic rel);
        bus_start;
        send_byte({a, 1'b1}, ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1; tick(Q); scl = 1; tick(Q / 2);
            v[i] = sda_line;
            tick(Q / 2); scl = 0;
        end
        tick(1);
        sda_m = 1; tick(Q); scl = 1; tick(Q / 2);
        rel = sda_line;
        tick(Q / 2); scl = 0; tick(Q);
        bus_stop;
    endtask

    task automatic abort_txn(input logic [7:0] ins, input logic [7:0] d, input logic use_start);
        logic ack;
        bus_start;
        send_byte({6'b010110, strap, 1'b0}, ack);
        send_byte(ins, ack);
        send_bits(d, 4);
        if (use_start) bus_start;
        bus_stop;
    endtask

    localparam logic [6:0] ADR0 = 7'b0101100;
    localparam logic [6:0] ADR1 = 7'b0101101;

    initial begin
        logic [2:0] acks;
        logic ack, rel;
        logic [7:0] v;
        void'($urandom(32'd4711));
        tick(5); rst = 0; tick(5);
        // R1 reset state
        chk_out("R1");
        chk("R1 sda_oe", {255'd0, sda_oe}, 256'd0);

        // R3 R6 basic write
        wr_txn(ADR0, 8'h00, 8'h3c, acks);
        chk("R3 acks", {253'd0, acks}, 256'd7);
        chk_out("R6");

        // R2 wrong address ignored
        wr_txn(ADR1, 8'h00, 8'h11, acks);
        chk("R2 no ack", {253'd0, acks}, 256'd0);
        chk_out("R2");
        wr_txn(7'b1101100, 8'h00, 8'h22, acks);
        chk("R2 prefix", {253'd0, acks}, 256'd0);
        chk_out("R2");
        strap = 1; tick(4);
        wr_txn(ADR1, 8'h00, 8'hff, acks);
        chk("R2 strap", {253'd0, acks}, 256'd7);
        chk_out("R2 strap");
        strap = 0; tick(4);

        // R4 don't-care bits
        wr_txn(ADR0, 8'h9f, 8'h05, acks);
        chk_out("R4");

        // R5 midscale priority
        wr_txn(ADR0, 8'h40, 8'h17, acks);
        chk("R5 pos", tap_sel, 256'd1 << 128);
        chk_out("R5");

        // R7 shutdown keeps value
        wr_txn(ADR0, 8'h00, 8'ha5, acks);
        wr_txn(ADR0, 8'h20, 8'ha5, acks);
        chk_out("R7");
        chk("R7 tap0", tap_sel, 256'd1);
        rd_txn(ADR0, ack, v, rel);
        chk("R7 read", {248'd0, v}, {248'd0, 8'ha5});

        // R8 update while parked, then restore
        wr_txn(ADR0, 8'h20, 8'h61, acks);
        chk_out("R8 parked");
        rd_txn(ADR0, ack, v, rel);
        chk("R8 stored", {248'd0, v}, {248'd0, 8'h61});
        bus_start; send_byte({ADR0, 1'b0}, ack); send_byte(8'h00, ack); send_byte(8'h61, ack); bus_stop;
        exp_sd = 0;
        chk("R8 restore", tap_sel, 256'd1 << 8'h61);

        // R9 read
        rd_txn(ADR0, ack, v, rel);
        chk("R9 ack", {255'd0, ack}, 256'd1);
        chk("R9 data", {248'd0, v}, {248'd0, 8'h61});
        chk("R9 release", {255'd0, rel}, 256'd1);

        // R10 R11 aborts
        abort_txn(8'h20, 8'h00, 1'b0);
        chk_out("R10 stop");
        abort_txn(8'h40, 8'hf0, 1'b1);
        chk_out("R10 start");
        bus_start; send_byte({ADR0, 1'b0}, ack); send_byte(8'h00, ack); send_byte(8'h99, ack);
        bus_start; bus_stop;
        exp_pos = 8'h99;
        chk_out("R11 commit");

        // random mix
        for (int n = 0; n < 40; n++) begin
            int kind;
            logic [7:0] ins, d;
            kind = $urandom_range(0, 4);
            ins = 8'($urandom);
            d = 8'($urandom);
            strap = 1'($urandom); tick(2);
            case (kind)
                0, 1: wr_txn({6'b010110, strap}, ins, d, acks);
                2: wr_txn({6'b010110, ~strap}, ins, d, acks);
                3: abort_txn(ins, d, 1'($urandom));
                default: begin
                    rd_txn({6'b010110, strap}, ack, v, rel);
                    chk("R9 rand", {248'd0, v}, {248'd0, exp_pos});
                end
            endcase
            chk_out("R6 rand");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule